// File: doc/BRIEF.md
# Prioritised 32-Line Interrupt Controller

This block gathers 32 external interrupt request lines and turns them into two processor interrupt outputs: a normal one and a critical one. Each line is first brought into the clock domain through a two-stage synchronizer. It is then qualified by its own polarity and sensing mode (level or edge) and latched into a sticky status register. Software clears a status bit by writing a 1 to it.

An enable register gates the status bits into a masked view. A routing register sends each enabled source to the normal or the critical output. A fixed-priority encoder reports the lowest-numbered pending masked source, and source 0 wins.

All state sits behind a small word-addressed register port. Writes take effect at the clock edge. Reads are combinational from the current register contents.

Top module: `pri_irq_ctrl`

## Requirements
- R1: Source n (0..31) occupies bit (31 − n) of every per-source register, so source 0 is bit 31.
- R2: Writing a 1 to a status bit clears it, unless the same source sets it again in that cycle. Writing 0 to a status bit leaves it unchanged.
- R3: Trigger register bit 0 selects level sensing. A level source sets its status bit in every cycle its synchronized input is active, so a clear has no effect while the input stays active.
- R4: Polarity register bit 0 makes the source active when its input is low. Bit 1 makes it active when its input is high.
- R5: Routing register bit 1 sends the source to `irq_norm_o`. Bit 0 sends it to `irq_crit_o`.
- R6: The masked-status register (word 2) reads as status AND enable. A disabled source never drives an output.
- R7: The priority register (word 6) returns, in bits 5:0, the smallest source number whose masked-status bit is set. It returns 32 when no masked-status bit is set. Bits 31:6 read 0.
- R8: Sources 17, 18 and 19 are reserved. Their status bits always read 0 and they never assert an output.
- R9: Each output is registered. It goes high at the clock edge after a masked-status bit routed to it becomes 1. It goes low at the edge after no such bit remains.
- R10: Trigger bit 1 selects edge sensing. The status bit sets on a transition of the synchronized input to its active level and stays set until cleared. A change on an input reaches the status register at the third rising edge after it is applied, because of the two synchronizer flops.
- R11: Reset values: status, enable, trigger and polarity are 0. Routing is all 1s. Both outputs are 0 and the priority register reads 32.
- R12: Word addresses: 0 status (read, write-1-to-clear), 1 enable, 2 masked status (read-only), 3 trigger, 4 polarity, 5 routing, 6 priority (read-only). Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | External interrupt request lines, asynchronous |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_norm_o | output | 1 | Normal interrupt output |
| irq_crit_o | output | 1 | Critical interrupt output |

## Verification
A level applied to `irq_in` just after a falling edge shows in the status register after three rising edges. It reaches an output one edge later. The bench therefore waits exactly three edges before reading status and a fourth before sampling the outputs.

A register write lands at the edge that ends the write cycle, and reads are combinational. Each check of a write's effect is made at the falling edge that follows. An output change caused by a write or a clear is checked one edge later still.

The sweep covers every source in level/active-low/normal mode and in edge/active-high/critical mode. This exercises the bit mapping, the reserved holes and the priority value for each index.

// File: rtl/pri_irq_pkg.sv
package pri_irq_pkg;
  localparam int NSRC  = 32;
  localparam int IDXW  = 6;
  localparam int AW    = 3;
  localparam int RSV_LO = 17;
  localparam int RSV_HI = 19;

  typedef enum logic [AW-1:0] {
    A_STAT  = 3'd0,
    A_ENAB  = 3'd1,
    A_MSTAT = 3'd2,
    A_TRIG  = 3'd3,
    A_POL   = 3'd4,
    A_ROUTE = 3'd5,
    A_PRIO  = 3'd6
  } reg_addr_e;

  // bit position of source n is NSRC-1-n
  function automatic logic [NSRC-1:0] rsvd_mask();
    logic [NSRC-1:0] m;
    m = '0;
    for (int n = RSV_LO; n <= RSV_HI; n++) m[NSRC-1-n] = 1'b1;
    return m;
  endfunction

  // lowest source number whose bit is set, NSRC if none
  function automatic logic [IDXW-1:0] first_pending(input logic [NSRC-1:0] v);
    logic [IDXW-1:0] r;
    r = IDXW'(NSRC);
    for (int n = NSRC-1; n >= 0; n--) if (v[NSRC-1-n]) r = IDXW'(n);
    return r;
  endfunction

  // set request: edge sources on a rising active level, level sources while active
  function automatic logic [NSRC-1:0] set_req(input logic [NSRC-1:0] act,
                                              input logic [NSRC-1:0] prev,
                                              input logic [NSRC-1:0] edge_sel);
    return (edge_sel & act & ~prev) | (~edge_sel & act);
  endfunction
endpackage

// File: rtl/pri_irq_sync.sv
module pri_irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pri_irq_capture.sv
module pri_irq_capture
  import pri_irq_pkg::*;
#(
  parameter int W = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_in,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] edge_sel,
  input  logic [W-1:0] clr,
  output logic [W-1:0] status
);
  localparam logic [W-1:0] RSVD = rsvd_mask();

  logic [W-1:0] active_w;
  logic [W-1:0] prev_q;
  logic [W-1:0] set_w;
  logic [W-1:0] status_d;

  assign active_w = ~(sync_in ^ pol);
  assign set_w    = set_req(active_w, prev_q, edge_sel) & ~RSVD;
  assign status_d = ((status & ~clr) | set_w) & ~RSVD;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_q <= '0;
      status <= '0;
    end else begin
      prev_q <= active_w;
      status <= status_d;
    end

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~set_w) != '0) |=> ((status & $past(clr & ~set_w)) == '0)); // R2
  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((status & $past(status & edge_sel & ~clr)) == $past(status & edge_sel & ~clr))); // R10
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((status & $past(active_w & ~edge_sel & ~RSVD)) == $past(active_w & ~edge_sel & ~RSVD))); // R3
endmodule

// File: rtl/pri_irq_ctrl.sv
module pri_irq_ctrl
  import pri_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_wr,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] reg_rdata,
  output logic            irq_norm_o,
  output logic            irq_crit_o
);
  localparam logic [NSRC-1:0] RSVD = rsvd_mask();

  logic [NSRC-1:0] enab_q, trig_q, pol_q, route_q;
  logic [NSRC-1:0] sync_w, clr_w, status_w, mstat_w;
  logic [NSRC-1:0] pend_norm_w, pend_crit_w;
  logic [IDXW-1:0] prio_w;

  pri_irq_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(irq_in), .q(sync_w));

  assign clr_w = (reg_wr && reg_addr == A_STAT) ? reg_wdata : '0;

  pri_irq_capture #(.W(NSRC)) cap_i (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_w), .pol(pol_q),
    .edge_sel(trig_q), .clr(clr_w), .status(status_w));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      enab_q  <= '0;
      trig_q  <= '0;
      pol_q   <= '0;
      route_q <= '1;
    end else if (reg_wr) begin
      case (reg_addr)
        A_ENAB:  enab_q  <= reg_wdata;
        A_TRIG:  trig_q  <= reg_wdata;
        A_POL:   pol_q   <= reg_wdata;
        A_ROUTE: route_q <= reg_wdata;
        default: ;
      endcase
    end

  assign mstat_w     = status_w & enab_q;
  assign pend_norm_w = mstat_w & route_q;
  assign pend_crit_w = mstat_w & ~route_q;
  assign prio_w      = first_pending(mstat_w);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_norm_o <= 1'b0;
      irq_crit_o <= 1'b0;
    end else begin
      irq_norm_o <= |pend_norm_w;
      irq_crit_o <= |pend_crit_w;
    end

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = status_w;
      A_ENAB:  reg_rdata = enab_q;
      A_MSTAT: reg_rdata = mstat_w;
      A_TRIG:  reg_rdata = trig_q;
      A_POL:   reg_rdata = pol_q;
      A_ROUTE: reg_rdata = route_q;
      A_PRIO:  reg_rdata = {{(NSRC-IDXW){1'b0}}, prio_w};
      default: reg_rdata = '0;
    endcase
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status_w & RSVD) == '0); // R8
  AST_NORM_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq_norm_o == $past(|(status_w & enab_q & route_q)))); // R9
  AST_CRIT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq_crit_o == $past(|(status_w & enab_q & ~route_q)))); // R5
  AST_PRIO_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_w == IDXW'(NSRC)) == (mstat_w == '0)); // R7
  AST_PRIO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mstat_w != '0) |-> mstat_w[NSRC-1-int'(prio_w)]); // R7
endmodule

// File: tb/pri_irq_ctrl_tb.sv
module pri_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = 32'hFFFF_FFFF;
  logic [2:0]  reg_addr = 3'd0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq_norm_o, irq_crit_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  pri_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_norm_o(irq_norm_o), .irq_crit_o(irq_crit_o));

  function automatic logic [31:0] pos(input int n);
    return 32'h8000_0000 >> n;
  endfunction

  function automatic bit is_rsv(input int n);
    return (n == 17) || (n == 18) || (n == 19);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, e;
    // R11 reset values
    wait_cyc(2);
    rd(3'd0, v); check("R11 status", v, 32'h0);
    rd(3'd1, v); check("R11 enable", v, 32'h0);
    rd(3'd3, v); check("R11 trig", v, 32'h0);
    rd(3'd4, v); check("R11 pol", v, 32'h0);
    rd(3'd5, v); check("R11 route", v, 32'hFFFF_FFFF);
    rd(3'd6, v); check("R11 prio", v, 32'd32);
    rd(3'd7, v); check("R12 addr7", v, 32'h0);
    check("R11 outs", {30'd0, irq_norm_o, irq_crit_o}, 32'h0);
    rst_n = 1'b1;
    wait_cyc(4);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); check("R2 initial clear", v, 32'h0);
    wr(3'd1, 32'hFFFF_FFFF);
    wait_cyc(1);

    // level, active low, normal route: every source
    for (int n = 0; n < 32; n++) begin
      e = is_rsv(n) ? 32'h0 : pos(n);
      irq_in = ~pos(n);
      wait_cyc(3);
      rd(3'd0, v); check($sformatf("R1 R4 R8 level status src%0d", n), v, e);
      rd(3'd6, v); check($sformatf("R7 prio src%0d", n), v, is_rsv(n) ? 32'd32 : 32'(n));
      wait_cyc(1);
      check($sformatf("R9 R5 norm src%0d", n), {31'd0, irq_norm_o}, is_rsv(n) ? 32'd0 : 32'd1);
      check($sformatf("R5 crit quiet src%0d", n), {31'd0, irq_crit_o}, 32'd0);
      wr(3'd0, 32'hFFFF_FFFF);
      rd(3'd0, v); check($sformatf("R3 clear while active src%0d", n), v, e);
      irq_in = 32'hFFFF_FFFF;
      wait_cyc(3);
      wr(3'd0, 32'h0);
      rd(3'd0, v); check($sformatf("R2 write0 src%0d", n), v, e);
      wr(3'd0, pos(n));
      rd(3'd0, v); check($sformatf("R2 w1c src%0d", n), v, 32'h0);
      check($sformatf("R9 norm held src%0d", n), {31'd0, irq_norm_o}, is_rsv(n) ? 32'd0 : 32'd1);
      wait_cyc(1);
      check($sformatf("R9 norm drop src%0d", n), {31'd0, irq_norm_o}, 32'd0);
    end

    // switch to edge, active high, critical route
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd4, 32'hFFFF_FFFF);
    irq_in = 32'h0;
    wait_cyc(4);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); check("R2 edge setup clear", v, 32'h0);
    wr(3'd5, 32'h0);
    wait_cyc(2);
    for (int n = 0; n < 32; n++) begin
      e = is_rsv(n) ? 32'h0 : pos(n);
      irq_in = pos(n);
      wait_cyc(1);
      irq_in = 32'h0;
      wait_cyc(2);
      rd(3'd0, v); check($sformatf("R10 R4 edge set src%0d", n), v, e);
      wait_cyc(4);
      rd(3'd0, v); check($sformatf("R10 sticky src%0d", n), v, e);
      check($sformatf("R5 crit src%0d", n), {31'd0, irq_crit_o}, is_rsv(n) ? 32'd0 : 32'd1);
      check($sformatf("R5 norm quiet src%0d", n), {31'd0, irq_norm_o}, 32'd0);
      wr(3'd0, pos(n));
      rd(3'd0, v); check($sformatf("R2 edge clear src%0d", n), v, 32'h0);
      wait_cyc(1);
      check($sformatf("R9 crit drop src%0d", n), {31'd0, irq_crit_o}, 32'd0);
    end

    // enable gating and priority ordering
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd1, 32'h0);
    e = pos(3) | pos(9) | pos(30);
    irq_in = e;
    wait_cyc(1);
    irq_in = 32'h0;
    wait_cyc(3);
    rd(3'd0, v); check("R10 multi status", v, e);
    rd(3'd2, v); check("R6 masked off", v, 32'h0);
    rd(3'd6, v); check("R7 none enabled", v, 32'd32);
    check("R6 no output", {30'd0, irq_norm_o, irq_crit_o}, 32'h0);
    wr(3'd1, pos(9));
    rd(3'd2, v); check("R6 partial mask", v, pos(9));
    rd(3'd6, v); check("R7 only 9", v, 32'd9);
    wait_cyc(1);
    check("R6 R9 enabled output", {31'd0, irq_norm_o}, 32'd1);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd2, v); check("R6 full mask", v, e);
    rd(3'd6, v); check("R7 highest 3", v, 32'd3);
    wr(3'd0, pos(3));
    rd(3'd6, v); check("R7 next 9", v, 32'd9);
    wr(3'd0, pos(9));
    rd(3'd6, v); check("R7 next 30", v, 32'd30);
    wr(3'd0, pos(30));
    rd(3'd6, v); check("R7 empty", v, 32'd32);
    wait_cyc(1);
    check("R9 all quiet", {30'd0, irq_norm_o, irq_crit_o}, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule